// File: doc/BRIEF.md
# Display Controller Command Byte Parser

This block sits behind the host link of a display controller and turns a stream of command bytes into settings. Each byte arrives with a one-cycle valid strobe. The first byte of a command is an opcode. The opcode decides how many parameter bytes follow: none, one, two, fifteen or sixty-four. The parser counts these bytes and writes each decoded value into a register file. The display datapath reads the register file directly. Commands that carry no parameters produce a one-cycle action pulse.

Two table loads are staged. These are the 64-entry icon current table and the 15-entry gray-level pulse width table. A new table becomes visible only when its last byte arrives, so the datapath never sees a half-written table.

A lock command makes the parser deaf to every opcode except the lock opcode itself. The matching unlock sequence reopens the parser.

Top module: `cmd_parser`

## Requirements
- R1: While and after reset, before any byte arrives, the outputs hold these values:
  - colStart = 0, colEnd = 63, rowStart = 0, rowEnd = 127.
  - Every settings slot is 0, except the multiplex slot, which is 127.
  - Every icon current is 0.
  - Gray entry k is 4*(k+1).
  - actionPulse = 0 and locked = 0.
- R2: Opcode 0x15 takes two bytes. The first sets colStart and the second sets colEnd, each from the byte's low 6 bits. Opcode 0x75 does the same for rowStart and rowEnd, using the low 7 bits. Each value appears one clock after its byte.
- R3: These opcodes each take one parameter byte: 0x81, 0x82, 0x90, 0x91, 0x93, 0x94, 0x95, 0x96, 0xa0, 0xa1, 0xa2, 0xa8, 0xb1, 0xb2, 0xb3, 0xbb, 0xbc, 0xbe. In that listed order they are numbered slot 0 to slot 17. Slot k is stored at settings[8k+7:8k] and is visible one clock after its parameter byte.
- R4: Opcodes 0xa4, 0xa5, 0xa6, 0xa7, 0xae, 0xaf and 0xb7 take no parameters. One clock after each, it raises actionPulse bit 0, 1, 2, 3, 4, 5 or 6 respectively, for exactly one cycle. Opcode 0xe3 changes no output.
- R5: The multiplex setting (opcode 0xa8, slot 11) accepts a parameter byte only if its value is 15 to 127. Any other value leaves the slot unchanged.
- R6: Opcode 0x92 is followed by 64 bytes. Byte i sets icon entry i, held at iconCurrents[7i+6:7i] from the byte's low 7 bits. The whole table changes together, one clock after the 64th byte, and not before.
- R7: Opcode 0xb8 is followed by 15 bytes. Byte k sets gray entry k (level k+1), held at grayWidths[6k+5:6k] from the byte's low 6 bits. The whole table changes together, one clock after the 15th byte.
- R8: Opcode 0xb7 restores every gray entry k to 4*(k+1), in the same cycle as its pulse.
- R9: Opcode 0xfd followed by 0x13 sets locked. Opcode 0xfd followed by 0x12 clears it. Any other byte after 0xfd leaves locked unchanged. Each change appears one clock after the parameter byte.
- R10: While locked, every byte received as an opcode, other than 0xfd, is dropped. It writes no register and raises no pulse.
- R11: An opcode not listed in R2 to R9 is a one-byte no-op. The byte after it is taken as an opcode.
- R12: A reset in the middle of a command abandons that command. The first byte after reset is taken as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| byteValid | input | 1 | Byte strobe, one byte per cycle it is high |
| byteIn | input | 8 | Command or parameter byte |
| colStart | output | 6 | Column window start |
| colEnd | output | 6 | Column window end |
| rowStart | output | 7 | Row window start |
| rowEnd | output | 7 | Row window end |
| settings | output | 144 | Eighteen single-byte settings, slot k at bits 8k+7:8k |
| iconCurrents | output | 448 | Committed icon current table, 7 bits per entry |
| grayWidths | output | 90 | Committed gray pulse widths, 6 bits per entry |
| actionPulse | output | 7 | One-cycle pulses for parameterless commands |
| locked | output | 1 | Command lock state |

## Verification
A wrong byte count or a wrong parser state shows one clock later. A parameter lands in the wrong register, or a parameter byte is taken as an opcode and fires a pulse or a write. Because of this, the bench compares every output against its model on every cycle.

A staging fault shows at the ports in one of two ways. Either a table entry moves mid-burst, or the table fails to move one clock after the final byte. Lock faults show up as settings that change or pulses that fire while locked is high.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

  localparam int IDX_W = 8;
  localparam int SLOT_COUNT = 18;
  localparam int SLOT_MUX = 11;
  localparam int PULSE_W = 7;
  localparam logic [7:0] OP_LOCK = 8'hfd;
  localparam logic [7:0] OP_GRAY_DEF = 8'hb7;

  typedef enum logic [2:0] {
    ST_NONE, ST_SINGLE, ST_COL, ST_ROW, ST_ICON, ST_GRAY, ST_LOCK
  } strobeKind_e;

  typedef struct packed {
    strobeKind_e        kind;
    logic [IDX_W-1:0]   idx;
    logic               last;
    logic [4:0]         slot;
    logic [7:0]         data;
    logic [PULSE_W-1:0] pulse;
    logic               grayDefault;
  } strobe_t;

  function automatic logic [4:0] slotOf(input logic [7:0] op);
    case (op)
      8'h81: return 5'd0;
      8'h82: return 5'd1;
      8'h90: return 5'd2;
      8'h91: return 5'd3;
      8'h93: return 5'd4;
      8'h94: return 5'd5;
      8'h95: return 5'd6;
      8'h96: return 5'd7;
      8'ha0: return 5'd8;
      8'ha1: return 5'd9;
      8'ha2: return 5'd10;
      8'ha8: return 5'd11;
      8'hb1: return 5'd12;
      8'hb2: return 5'd13;
      8'hb3: return 5'd14;
      8'hbb: return 5'd15;
      8'hbc: return 5'd16;
      8'hbe: return 5'd17;
      default: return 5'd31;
    endcase
  endfunction

  function automatic strobeKind_e kindOf(input logic [7:0] op);
    case (op)
      8'h15:   return ST_COL;
      8'h75:   return ST_ROW;
      8'h92:   return ST_ICON;
      8'hb8:   return ST_GRAY;
      OP_LOCK: return ST_LOCK;
      default: return (slotOf(op) != 5'd31) ? ST_SINGLE : ST_NONE;
    endcase
  endfunction

  function automatic int paramsOf(input logic [7:0] op, input int iconCount, input int grayCount);
    case (kindOf(op))
      ST_COL, ST_ROW:    return 2;
      ST_ICON:           return iconCount;
      ST_GRAY:           return grayCount;
      ST_LOCK, ST_SINGLE: return 1;
      default:           return 0;
    endcase
  endfunction

  function automatic logic [PULSE_W-1:0] pulseOf(input logic [7:0] op);
    case (op)
      8'ha4: return 7'b0000001;
      8'ha5: return 7'b0000010;
      8'ha6: return 7'b0000100;
      8'ha7: return 7'b0001000;
      8'hae: return 7'b0010000;
      8'haf: return 7'b0100000;
      8'hb7: return 7'b1000000;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/cmdp_ctrl.sv
module cmdp_ctrl
  import cmdp_pkg::*;
#(
  parameter int ICON_COUNT  = 64,
  parameter int GRAY_LEVELS = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  logic       locked,
  output strobe_t    stb
);

  logic             inParamQ, inParamD;
  logic [7:0]       opQ, opD;
  logic [IDX_W-1:0] cntQ, cntD, lastQ, lastD;
  logic [IDX_W:0]   needW;

  always_comb begin
    stb          = '0;
    stb.kind     = ST_NONE;
    stb.data     = byteIn;
    stb.idx      = cntQ;
    stb.slot     = slotOf(opQ);
    inParamD     = inParamQ;
    opD          = opQ;
    cntD         = cntQ;
    lastD        = lastQ;
    needW        = '0;
    if (byteValid) begin
      if (!inParamQ) begin
        if (!locked || byteIn == OP_LOCK) begin
          needW = (IDX_W+1)'(paramsOf(byteIn, ICON_COUNT, GRAY_LEVELS));
          if (needW == '0) begin
            stb.pulse       = pulseOf(byteIn);
            stb.grayDefault = (byteIn == OP_GRAY_DEF);
          end else begin
            inParamD = 1'b1;
            opD      = byteIn;
            cntD     = '0;
            lastD    = IDX_W'(needW - 9'd1);
          end
        end
      end else begin
        stb.last = (cntQ == lastQ);
        stb.kind = kindOf(opQ);
        if (stb.last) inParamD = 1'b0;
        else          cntD     = cntQ + 8'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inParamQ <= 1'b0;
      opQ      <= '0;
      cntQ     <= '0;
      lastQ    <= '0;
    end else begin
      inParamQ <= inParamD;
      opQ      <= opD;
      cntQ     <= cntD;
      lastQ    <= lastD;
    end
  end

  // R4: at most one action strobe per byte
  a_r4_pulse_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.pulse));

  // R10: a dropped opcode while locked emits nothing
  a_r10_locked_drop: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !inParamQ && byteValid && byteIn != OP_LOCK)
      |=> (!inParamQ && $stable(opQ)));

endmodule

// File: rtl/cmdp_regs.sv
module cmdp_regs
  import cmdp_pkg::*;
#(
  parameter int ICON_COUNT  = 64,
  parameter int ICON_W      = 7,
  parameter int GRAY_LEVELS = 15,
  parameter int GRAY_W      = 6,
  parameter int COL_W       = 6,
  parameter int ROW_W       = 7
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         stb,
  output logic [COL_W-1:0]                colStart,
  output logic [COL_W-1:0]                colEnd,
  output logic [ROW_W-1:0]                rowStart,
  output logic [ROW_W-1:0]                rowEnd,
  output logic [SLOT_COUNT*8-1:0]         settings,
  output logic [ICON_COUNT*ICON_W-1:0]    iconCurrents,
  output logic [GRAY_LEVELS*GRAY_W-1:0]   grayWidths,
  output logic [PULSE_W-1:0]              actionPulse,
  output logic                            locked
);

  localparam logic [7:0] MUX_MIN = 8'd15;
  localparam logic [7:0] MUX_MAX = 8'd127;

  logic [7:0]        slotQ     [SLOT_COUNT];
  logic [ICON_W-1:0] iconStage [ICON_COUNT];
  logic [ICON_W-1:0] iconTbl   [ICON_COUNT];
  logic [GRAY_W-1:0] grayStage [GRAY_LEVELS];
  logic [GRAY_W-1:0] grayTbl   [GRAY_LEVELS];

  function automatic logic [GRAY_W-1:0] grayDefault(input int k);
    return GRAY_W'((k + 1) * 4);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colStart    <= '0;
      colEnd      <= '1;
      rowStart    <= '0;
      rowEnd      <= '1;
      locked      <= 1'b0;
      actionPulse <= '0;
      for (int s = 0; s < SLOT_COUNT; s++) slotQ[s] <= (s == SLOT_MUX) ? MUX_MAX : 8'd0;
      for (int i = 0; i < ICON_COUNT; i++) begin
        iconStage[i] <= '0;
        iconTbl[i]   <= '0;
      end
      for (int k = 0; k < GRAY_LEVELS; k++) begin
        grayStage[k] <= '0;
        grayTbl[k]   <= grayDefault(k);
      end
    end else begin
      actionPulse <= stb.pulse;
      if (stb.grayDefault)
        for (int k = 0; k < GRAY_LEVELS; k++) grayTbl[k] <= grayDefault(k);
      case (stb.kind)
        ST_COL: if (stb.idx == '0) colStart <= stb.data[COL_W-1:0];
                else               colEnd   <= stb.data[COL_W-1:0];
        ST_ROW: if (stb.idx == '0) rowStart <= stb.data[ROW_W-1:0];
                else               rowEnd   <= stb.data[ROW_W-1:0];
        ST_SINGLE: begin
          if (int'(stb.slot) != SLOT_MUX || (stb.data >= MUX_MIN && stb.data <= MUX_MAX))
            slotQ[stb.slot] <= stb.data;
        end
        ST_ICON: begin
          if (stb.last)
            for (int i = 0; i < ICON_COUNT; i++)
              iconTbl[i] <= (stb.idx == IDX_W'(i)) ? stb.data[ICON_W-1:0] : iconStage[i];
          else
            iconStage[stb.idx] <= stb.data[ICON_W-1:0];
        end
        ST_GRAY: begin
          if (stb.last)
            for (int k = 0; k < GRAY_LEVELS; k++)
              grayTbl[k] <= (stb.idx == IDX_W'(k)) ? stb.data[GRAY_W-1:0] : grayStage[k];
          else
            grayStage[stb.idx] <= stb.data[GRAY_W-1:0];
        end
        ST_LOCK: begin
          if (stb.data == 8'h13) locked <= 1'b1;
          else if (stb.data == 8'h12) locked <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    assign settings[8*s +: 8] = slotQ[s];
  end
  for (genvar i = 0; i < ICON_COUNT; i++) begin : g_icon
    assign iconCurrents[ICON_W*i +: ICON_W] = iconTbl[i];
  end
  for (genvar k = 0; k < GRAY_LEVELS; k++) begin : g_gray
    assign grayWidths[GRAY_W*k +: GRAY_W] = grayTbl[k];
  end

  a_r5_mux_range: assert property (@(posedge clk) disable iff (!rstN)
    (settings[8*SLOT_MUX +: 8] >= MUX_MIN && settings[8*SLOT_MUX +: 8] <= MUX_MAX));

  a_r6_icon_commit_only: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.kind == ST_ICON && stb.last) |=> $stable(iconCurrents));

  a_r7_gray_commit_only: assert property (@(posedge clk) disable iff (!rstN)
    !((stb.kind == ST_GRAY && stb.last) || stb.grayDefault) |=> $stable(grayWidths));

  a_r9_lock_via_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind != ST_LOCK) |=> $stable(locked));

endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmdp_pkg::*;
#(
  parameter int ICON_COUNT  = 64,
  parameter int ICON_W      = 7,
  parameter int GRAY_LEVELS = 15,
  parameter int GRAY_W      = 6,
  parameter int COL_W       = 6,
  parameter int ROW_W       = 7
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          byteValid,
  input  logic [7:0]                    byteIn,
  output logic [COL_W-1:0]              colStart,
  output logic [COL_W-1:0]              colEnd,
  output logic [ROW_W-1:0]              rowStart,
  output logic [ROW_W-1:0]              rowEnd,
  output logic [SLOT_COUNT*8-1:0]       settings,
  output logic [ICON_COUNT*ICON_W-1:0]  iconCurrents,
  output logic [GRAY_LEVELS*GRAY_W-1:0] grayWidths,
  output logic [PULSE_W-1:0]            actionPulse,
  output logic                          locked
);

  strobe_t stb;

  cmdp_ctrl #(.ICON_COUNT(ICON_COUNT), .GRAY_LEVELS(GRAY_LEVELS)) i_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .locked(locked), .stb(stb)
  );

  cmdp_regs #(
    .ICON_COUNT(ICON_COUNT), .ICON_W(ICON_W), .GRAY_LEVELS(GRAY_LEVELS),
    .GRAY_W(GRAY_W), .COL_W(COL_W), .ROW_W(ROW_W)
  ) i_regs (
    .clk(clk), .rstN(rstN), .stb(stb),
    .colStart(colStart), .colEnd(colEnd), .rowStart(rowStart), .rowEnd(rowEnd),
    .settings(settings), .iconCurrents(iconCurrents), .grayWidths(grayWidths),
    .actionPulse(actionPulse), .locked(locked)
  );

endmodule

// File: tb/test_cmd_parser.sv
`timescale 1ns/1ps
module test_cmd_parser;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         byteValid = 1'b0;
  logic [7:0]   byteIn = 8'h00;
  logic [5:0]   colStart, colEnd;
  logic [6:0]   rowStart, rowEnd;
  logic [143:0] settings;
  logic [447:0] iconCurrents;
  logic [89:0]  grayWidths;
  logic [6:0]   actionPulse;
  logic         locked;

  always #2 clk = ~clk;

  cmd_parser i_cmd_parser (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .colStart(colStart), .colEnd(colEnd), .rowStart(rowStart), .rowEnd(rowEnd),
    .settings(settings), .iconCurrents(iconCurrents), .grayWidths(grayWidths),
    .actionPulse(actionPulse), .locked(locked)
  );

  int checks = 0;
  int fails = 0;

  // reference model state
  int eColS, eColE, eRowS, eRowE, eLocked, ePulse;
  int eSet[18];
  int eIcon[64];
  int eGray[15];
  int pend[$];
  int mBusy, mOp, mNeed;
  byte unsigned slotOps[18] = '{8'h81, 8'h82, 8'h90, 8'h91, 8'h93, 8'h94, 8'h95, 8'h96, 8'ha0,
                                8'ha1, 8'ha2, 8'ha8, 8'hb1, 8'hb2, 8'hb3, 8'hbb, 8'hbc, 8'hbe};
  byte unsigned actOps[7] = '{8'ha4, 8'ha5, 8'ha6, 8'ha7, 8'hae, 8'haf, 8'hb7};

  function automatic int slotIndex(input int op);
    foreach (slotOps[s]) if (slotOps[s] == op) return s;
    return -1;
  endfunction

  function automatic int needOf(input int op);
    if (op == 8'h15 || op == 8'h75) return 2;
    if (op == 8'h92) return 64;
    if (op == 8'hb8) return 15;
    if (op == 8'hfd || slotIndex(op) >= 0) return 1;
    return 0;
  endfunction

  task automatic modelReset();
    eColS = 0; eColE = 63; eRowS = 0; eRowE = 127; eLocked = 0; ePulse = 0;
    foreach (eSet[s]) eSet[s] = (s == 11) ? 127 : 0;
    foreach (eIcon[i]) eIcon[i] = 0;
    foreach (eGray[k]) eGray[k] = 4 * (k + 1);
    pend.delete();
    mBusy = 0; mOp = 0; mNeed = 0;
  endtask

  task automatic modelByte(input int b);
    if (!mBusy) begin
      if (eLocked && b != 8'hfd) return;
      mNeed = needOf(b);
      if (mNeed == 0) begin
        foreach (actOps[a]) if (actOps[a] == b) ePulse = 1 << a;
        if (b == 8'hb7) foreach (eGray[k]) eGray[k] = 4 * (k + 1);
      end else begin
        mBusy = 1; mOp = b; pend.delete();
      end
    end else begin
      pend.push_back(b);
      if (mOp == 8'h15) begin
        if (pend.size() == 1) eColS = b & 63; else eColE = b & 63;
      end else if (mOp == 8'h75) begin
        if (pend.size() == 1) eRowS = b & 127; else eRowE = b & 127;
      end
      if (pend.size() == mNeed) begin
        mBusy = 0;
        if (mOp == 8'h92) foreach (eIcon[i]) eIcon[i] = pend[i] & 127;
        else if (mOp == 8'hb8) foreach (eGray[k]) eGray[k] = pend[k] & 63;
        else if (mOp == 8'hfd) begin
          if (b == 8'h13) eLocked = 1;
          else if (b == 8'h12) eLocked = 0;
        end else if (slotIndex(mOp) >= 0) begin
          if (slotIndex(mOp) != 11 || (b >= 15 && b <= 127)) eSet[slotIndex(mOp)] = b;
        end
      end
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2", "colStart", int'(colStart), eColS);
    chk("R2", "colEnd", int'(colEnd), eColE);
    chk("R2", "rowStart", int'(rowStart), eRowS);
    chk("R2", "rowEnd", int'(rowEnd), eRowE);
    for (int s = 0; s < 18; s++)
      chk((s == 11) ? "R5" : "R3", $sformatf("slot%0d", s), int'(settings[8*s +: 8]), eSet[s]);
    for (int i = 0; i < 64; i++)
      chk("R6", $sformatf("icon%0d", i), int'(iconCurrents[7*i +: 7]), eIcon[i]);
    for (int k = 0; k < 15; k++)
      chk("R7/R8", $sformatf("gray%0d", k), int'(grayWidths[6*k +: 6]), eGray[k]);
    chk("R4", "actionPulse", int'(actionPulse), ePulse);
    chk("R9", "locked", int'(locked), eLocked);
  endtask

  task automatic step(input bit v, input int b);
    @(negedge clk);
    compare();
    ePulse = 0;
    byteValid = v;
    byteIn = 8'(b);
    if (v) modelByte(b);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) step(1'b0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    compare();
    rstN = 1'b0;
    byteValid = 1'b0;
    modelReset();
    @(negedge clk);
    compare();  // R1 / R12: reset values while held
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    modelReset();
    @(negedge clk);
    compare();          // R1 reset state
    rstN = 1'b1;
    idle(2);

    // R2 windows with masking
    step(1, 8'h15); step(1, 8'hc5); step(1, 8'h3e);
    step(1, 8'h75); step(1, 8'hff); step(1, 8'h10);
    // R3 single-parameter settings
    step(1, 8'h81); step(1, 8'h5a);
    step(1, 8'hbe); step(1, 8'hf0);
    step(1, 8'ha0); step(1, 8'h04);
    step(1, 8'h95); step(1, 8'h33);
    // R5 multiplex range
    step(1, 8'ha8); step(1, 8'h0e);
    step(1, 8'ha8); step(1, 8'h0f);
    step(1, 8'ha8); step(1, 8'h80);
    step(1, 8'ha8); step(1, 8'h40);
    // R4 action pulses, including no-op 0xe3
    foreach (actOps[a]) step(1, actOps[a]);
    step(1, 8'he3); idle(2);
    // R7 gray table load, then R8 default restore
    step(1, 8'hb8);
    for (int k = 0; k < 15; k++) step(1, (k * 5 + 200) & 255);
    idle(2);
    step(1, 8'hb7); idle(2);
    // R6 icon burst with high bits set in some bytes
    step(1, 8'h92);
    for (int i = 0; i < 64; i++) step(1, (i * 37 + 11) & 255);
    idle(2);
    // R11 unknown opcode followed by a real one
    step(1, 8'h00); step(1, 8'h82); step(1, 8'h77);
    step(1, 8'hc9); step(1, 8'hbb); step(1, 8'h09);
    // R9 lock / R10 locked drops
    step(1, 8'hfd); step(1, 8'h13);
    step(1, 8'h81); step(1, 8'h22);
    step(1, 8'ha5); step(1, 8'h15); step(1, 8'h01);
    step(1, 8'hb7);
    step(1, 8'hfd); step(1, 8'h55);
    step(1, 8'hfd); step(1, 8'h12);
    step(1, 8'h81); step(1, 8'h23);
    // R12 reset mid-burst
    step(1, 8'h92);
    for (int i = 0; i < 10; i++) step(1, i + 1);
    doReset();
    step(1, 8'h81); step(1, 8'h44);
    step(1, 8'hb8);
    for (int k = 0; k < 6; k++) step(1, k);
    doReset();
    step(1, 8'ha7);
    idle(3);
    summary();
  end

endmodule